// File: doc/BRIEF.md
# Serial Management Bus Master

This block is the station side of a two-wire PHY management bus. It divides the system clock into a management clock, and it turns one host command at a time into a serial frame on the data line. The data line is bidirectional off chip. Here it is split into a driven value, an output enable and a returned value, so that a pad cell outside the block can combine them.

The host presents a PHY address, a register address, a read/write selector and write data, together with a one-cycle valid strobe. The block then sends the frame: a run of ones as a preamble, the control field, a turnaround slot and sixteen data bits. The block drives the data bits on a write. On a read it releases the line for the turnaround slot and the data bits, and samples the PHY's bits late in each clock-low phase. When the frame ends the block raises a one-cycle completion pulse, and for a read it publishes the captured word.

Top module: `mdio_master`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done`, `mdc` and `mdio_oe` are 0 and `rd_data` is 0.
- R2: During a frame `mdc` starts low and toggles every `HALF_CYC` system clocks, so each frame has exactly 64 rising edges at a period of 2*`HALF_CYC` clocks. With the default of 20 at 100 MHz this is 400 ns. When idle, `mdc` stays low.
- R3: The first 32 bit slots of every frame carry a 1 with `mdio_oe` high.
- R4: Slots 32 to 45, sent MSB first, are: start code 01, then operation code 01 for a write or 10 for a read, then the 5-bit PHY address, then the 5-bit register address.
- R5: On a write, slots 46 and 47 carry 1 then 0, slots 48 to 63 carry the write data MSB first, and `mdio_oe` is high in all 64 slots.
- R6: On a read, `mdio_oe` is high in slots 0 to 45 and low in slots 46 to 63.
- R7: `mdio_out` changes only on the clock edge where `mdc` falls or a command is accepted. It therefore holds through the whole high phase and the whole low phase before each rise.
- R8: On a read, the bits on `mdio_in` for slots 48 to 63 are captured MSB first, after two synchronizer stages, on the last system clock of each slot's low phase. A PHY that changes the line up to 300 ns after the previous `mdc` rise is read correctly.
- R9: `busy` rises on the clock edge after `cmd_valid` is accepted. `done` is high for exactly one clock at the falling `mdc` edge that ends slot 63, and `busy` is low in that cycle.
- R10: `cmd_valid` while `busy` is high is ignored: the running frame is unchanged and no further frame starts.
- R11: `rd_data` changes only together with `done` at the end of a read. Write frames leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, accepted when not busy |
| cmd_read | input | 1 | 1 = read access, 0 = write access |
| cmd_phy | input | 5 | Target PHY address |
| cmd_reg | input | 5 | Target register address |
| cmd_wdata | input | 16 | Write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Last word read |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Value driven on the data line |
| mdio_oe | output | 1 | Drive enable for the data line |
| mdio_in | input | 1 | Value seen on the data line |

## Verification
Frames go out with all-zero and all-one address and data fields, which separates a stuck or swapped field from a correct one. Alternating read words such as 0xAAAA and 0x0001 expose bit-order and off-by-one capture faults. Random commands then mix reads and writes with a PHY model that changes `mdio_in` anywhere from 0 to 290 ns after each rise, which shows whether sampling sits late enough in the low phase. Commands injected mid-frame with inverted fields, and writes that follow reads, separate a correct busy lockout and read-data hold from designs that reload state.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int PRE_BITS   = 32;
  localparam int CTRL_BITS  = 2 + 2 + ADDR_W + ADDR_W + 2;
  localparam int FRAME_BITS = PRE_BITS + CTRL_BITS + DATA_W;
  localparam int TA_SLOT    = PRE_BITS + CTRL_BITS - 2;
  localparam int DATA_SLOT  = PRE_BITS + CTRL_BITS;

  localparam logic [1:0] SOF_CODE = 2'b01;
  localparam logic [1:0] OP_WR    = 2'b01;
  localparam logic [1:0] OP_RD    = 2'b10;
  localparam logic [1:0] TA_WR    = 2'b10;

  typedef enum logic {ST_IDLE, ST_RUN} seq_state_e;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] reg_a;
    logic [DATA_W-1:0] wdata;
  } mgmt_cmd_t;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int HALF_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic fall_stb,
  output logic smp_stb
);
  localparam int CW = $clog2(HALF_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          at_end;

  assign at_end   = run && (cnt_q == LAST);
  assign fall_stb = at_end && mdc_q;
  assign smp_stb  = at_end && !mdc_q;
  assign mdc      = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  // R2
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !$past(run)) |-> !mdc_q);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  mgmt_cmd_t         cmd,
  input  logic              fall_stb,
  input  logic              smp_stb,
  input  logic              mdi,
  output logic              run,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              mdo,
  output logic              mdo_en
);
  localparam int SW = $clog2(FRAME_BITS);
  localparam logic [SW-1:0] TA_IDX   = SW'(TA_SLOT);
  localparam logic [SW-1:0] DAT_IDX  = SW'(DATA_SLOT);
  localparam logic [SW-1:0] LAST_IDX = SW'(FRAME_BITS - 1);

  seq_state_e            state_q, state_d;
  logic [SW-1:0]         slot_q, slot_d;
  logic [FRAME_BITS-1:0] frame_q, frame_d;
  logic                  rd_q, rd_d;
  logic [DATA_W-1:0]     shin_q, shin_d;
  logic [DATA_W-1:0]     rdat_q, rdat_d;
  logic                  done_q, done_d;

  always_comb begin
    state_d = state_q;
    slot_d  = slot_q;
    frame_d = frame_q;
    rd_d    = rd_q;
    shin_d  = shin_q;
    rdat_d  = rdat_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          state_d = ST_RUN;
          slot_d  = '0;
          rd_d    = cmd.rd;
          frame_d = {{PRE_BITS{1'b1}}, SOF_CODE, (cmd.rd ? OP_RD : OP_WR),
                     cmd.phy, cmd.reg_a, (cmd.rd ? 2'b11 : TA_WR),
                     (cmd.rd ? {DATA_W{1'b1}} : cmd.wdata)};
        end
      end
      default: begin
        if (smp_stb && rd_q && (slot_q >= DAT_IDX))
          shin_d = {shin_q[DATA_W-2:0], mdi};
        if (fall_stb) begin
          if (slot_q == LAST_IDX) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            if (rd_q) rdat_d = shin_q;
          end else begin
            slot_d  = slot_q + 1'b1;
            frame_d = {frame_q[FRAME_BITS-2:0], 1'b1};
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      frame_q <= '1;
      rd_q    <= 1'b0;
      shin_q  <= '0;
      rdat_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      frame_q <= frame_d;
      rd_q    <= rd_d;
      shin_q  <= shin_d;
      rdat_q  <= rdat_d;
      done_q  <= done_d;
    end
  end

  assign run     = (state_q == ST_RUN);
  assign done    = done_q;
  assign rd_data = rdat_q;
  assign mdo     = run ? frame_q[FRAME_BITS-1] : 1'b1;
  assign mdo_en  = run && !(rd_q && (slot_q >= TA_IDX));

  // R10
  op_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |=> $stable(rd_q));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_mgmt_pkg::*;
#(
  parameter int HALF_CYC = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_read,
  input  logic [ADDR_W-1:0] cmd_phy,
  input  logic [ADDR_W-1:0] cmd_reg,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              mdc,
  output logic              mdio_out,
  output logic              mdio_oe,
  input  logic              mdio_in
);
  localparam int PW = $clog2(HALF_CYC + 2);

  logic      rst_meta_q, rst_sync_n;
  logic      mdi_meta_q, mdi_q;
  logic      run, fall_stb, smp_stb;
  mgmt_cmd_t cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mdi_meta_q <= 1'b1;
      mdi_q      <= 1'b1;
    end else begin
      mdi_meta_q <= mdio_in;
      mdi_q      <= mdi_meta_q;
    end
  end

  assign cmd = '{rd: cmd_read, phy: cmd_phy, reg_a: cmd_reg, wdata: cmd_wdata};

  mdio_mdc_gen #(.HALF_CYC(HALF_CYC)) u_clkgen (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (run),
    .mdc      (mdc),
    .fall_stb (fall_stb),
    .smp_stb  (smp_stb)
  );

  mdio_frame_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cmd_valid (cmd_valid),
    .cmd       (cmd),
    .fall_stb  (fall_stb),
    .smp_stb   (smp_stb),
    .mdi       (mdi_q),
    .run       (run),
    .done      (done),
    .rd_data   (rd_data),
    .mdo       (mdio_out),
    .mdo_en    (mdio_oe)
  );

  assign busy = run;

  logic          mdc_seen_q;
  logic [PW-1:0] ph_cnt_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mdc_seen_q <= 1'b0;
      ph_cnt_q   <= '0;
    end else begin
      mdc_seen_q <= mdc;
      if (!busy)                  ph_cnt_q <= '0;
      else if (mdc != mdc_seen_q) ph_cnt_q <= PW'(1);
      else                        ph_cnt_q <= ph_cnt_q + 1'b1;
    end
  end

  // R2
  mdc_phase_len_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(mdc) |-> (ph_cnt_q == PW'(HALF_CYC)));

  // R7
  mdo_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mdc && $past(mdc)) |-> $stable(mdio_out));

  // R3
  preamble_start_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(busy) |-> (mdio_oe && mdio_out && !mdc));

  // R9
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> ($past(busy) && !busy));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !done |-> $stable(rd_data));
endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  localparam int HALF = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_read;
  logic [4:0]  cmd_phy, cmd_reg;
  logic [15:0] cmd_wdata;
  logic        busy, done, mdc, mdio_out, mdio_oe;
  logic [15:0] rd_data;
  logic        mdio_in;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mdio_master #(.HALF_CYC(HALF)) u_mdio_master (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_read(cmd_read),
    .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
    .busy(busy), .done(done), .rd_data(rd_data), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  // monitor state
  logic [63:0] cap_out, cap_oe;
  int   cap_idx, per_cnt, min_per, max_per, hi_bad, chg_bad, done_cnt;
  bit   seen_rise;
  logic prev_mdc = 1'b0, prev_out = 1'b1, prev_busy = 1'b0, hi_val = 1'b1;

  always @(negedge clk) begin
    if (mdc && !prev_mdc) begin
      if (cap_idx < 64) begin
        cap_out[63-cap_idx] = mdio_out;
        cap_oe[63-cap_idx]  = mdio_oe;
      end
      cap_idx++;
      if (seen_rise) begin
        if (per_cnt + 1 < min_per) min_per = per_cnt + 1;
        if (per_cnt + 1 > max_per) max_per = per_cnt + 1;
      end
      per_cnt = 0;
      seen_rise = 1;
      hi_val = mdio_out;
    end else begin
      per_cnt++;
    end
    if (mdc && mdio_out !== hi_val) hi_bad++;
    if (mdio_out !== prev_out && !(prev_mdc && !mdc) && !(busy && !prev_busy)) chg_bad++;
    if (done) done_cnt++;
    prev_mdc = mdc; prev_out = mdio_out; prev_busy = busy;
  end

  // PHY model: launches each read bit 0..29 clocks after the mdc rise
  int          phy_rise;
  bit          phy_rd;
  logic [15:0] phy_data;
  int          pr, pd;
  always @(posedge mdc) begin
    pr = phy_rise;
    phy_rise++;
    if (phy_rd && pr >= 46 && pr <= 62) begin
      pd = $urandom_range(0, 29);
      repeat (pd) @(negedge clk);
      mdio_in = (pr == 46) ? 1'b0 : phy_data[15-(pr-47)];
    end else if (pr == 63) begin
      mdio_in = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] p,
                                            input logic [4:0] r, input logic [15:0] w);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), p, r, 2'b10, w};
  endfunction

  function automatic logic [63:0] exp_oe(input bit rd);
    return rd ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
  endfunction

  task automatic run_cmd(input bit rd, input logic [4:0] p, input logic [4:0] r,
                         input logic [15:0] w, input logic [15:0] pdat, input bit poke);
    logic [15:0] prior;
    logic [63:0] ef, eo;
    int n;
    prior = rd_data;
    ef = exp_frame(rd, p, r, w);
    eo = exp_oe(rd);
    @(negedge clk);
    cap_idx = 0; phy_rise = 0; phy_rd = rd; phy_data = pdat;
    done_cnt = 0; hi_bad = 0; chg_bad = 0; min_per = 100000; max_per = 0; seen_rise = 0;
    cmd_valid = 1'b1; cmd_read = rd; cmd_phy = p; cmd_reg = r; cmd_wdata = w;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy === 1'b1, "R9", "busy after accept", 64'(busy), 64'd1);
    if (poke) begin
      repeat (300) @(negedge clk);
      cmd_valid = 1'b1; cmd_read = ~rd; cmd_phy = ~p; cmd_reg = ~r; cmd_wdata = ~w;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    n = 0;
    while (done !== 1'b1 && n < 6000) begin
      @(negedge clk);
      n++;
    end
    chk(n < 6000, "R9", "done seen", 64'(n), 64'd0);
    chk(busy === 1'b0, "R9", "busy low with done", 64'(busy), 64'd0);
    if (rd) chk(rd_data === pdat, "R8", "read word", 64'(rd_data), 64'(pdat));
    else    chk(rd_data === prior, "R11", "rd_data after write", 64'(rd_data), 64'(prior));
    @(negedge clk);
    chk(done === 1'b0, "R9", "done one cycle", 64'(done), 64'd0);
    chk(cap_out[63:32] === 32'hFFFF_FFFF && cap_oe[63:32] === 32'hFFFF_FFFF,
        "R3", "preamble", cap_out, ef);
    chk(cap_out[31:18] === ef[31:18] && cap_oe[31:18] === 14'h3FFF,
        "R4", "control field", 64'(cap_out[31:18]), 64'(ef[31:18]));
    if (rd) chk(cap_oe === eo, "R6", "read drive enables", cap_oe, eo);
    else    chk(cap_out[17:0] === ef[17:0] && cap_oe === eo,
                "R5", "write turnaround/data", 64'(cap_out[17:0]), 64'(ef[17:0]));
    chk(cap_idx == 64, "R2", "rising edges per frame", 64'(cap_idx), 64'd64);
    chk(min_per == 2*HALF && max_per == 2*HALF, "R2", "mdc period",
        64'(min_per), 64'(2*HALF));
    chk(hi_bad == 0 && chg_bad == 0, "R7", "data line timing", 64'(hi_bad + chg_bad), 64'd0);
    if (poke) begin
      repeat (200) @(negedge clk);
      chk(busy === 1'b0 && cap_idx == 64, "R10", "no frame from ignored command",
          64'(cap_idx), 64'd64);
    end
    chk(done_cnt == 1, "R9", "done pulse count", 64'(done_cnt), 64'd1);
  endtask

  initial begin
    void'($urandom(32'h5eed_0a1d));
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_read = 1'b0; cmd_phy = '0; cmd_reg = '0;
    cmd_wdata = '0; mdio_in = 1'b1; phy_rise = 0; phy_rd = 0; phy_data = '0;
    cap_idx = 0; cap_out = '0; cap_oe = '0;
    repeat (5) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && mdc === 1'b0 && mdio_oe === 1'b0 && rd_data === 16'h0,
        "R1", "in reset", {busy, done, mdc, mdio_oe, rd_data}, 64'd0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && mdc === 1'b0 && mdio_oe === 1'b0 && rd_data === 16'h0,
        "R1", "after reset", {busy, done, mdc, mdio_oe, rd_data}, 64'd0);
    repeat (100) @(negedge clk);
    chk(mdc === 1'b0, "R2", "idle mdc", 64'(mdc), 64'd0);

    run_cmd(0, 5'h00, 5'h00, 16'h0000, 16'h0, 0);
    run_cmd(0, 5'h1F, 5'h1F, 16'hFFFF, 16'h0, 0);
    run_cmd(1, 5'h01, 5'h02, 16'h0, 16'hAAAA, 0);
    run_cmd(1, 5'h1E, 5'h11, 16'h0, 16'h0001, 1);
    run_cmd(0, 5'h0A, 5'h15, 16'h8001, 16'h0, 1);
    run_cmd(1, 5'h00, 5'h1F, 16'h0, 16'h8000, 0);
    for (int i = 0; i < 10; i++) begin
      run_cmd($urandom_range(0, 1), 5'($urandom), 5'($urandom), 16'($urandom),
              16'($urandom), (i % 4) == 3);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule